// File: doc/BRIEF.md
# Serial LED Shift Controller

This block drives a daisy chain of up to three external 8-bit serial-in, parallel-out shift registers, typically used for status LEDs. Software programs it through a small 32-bit register window. On each refresh the block builds a 24-bit output word and shifts it out most-significant bit first. The shift uses a serial data line and a shift clock whose active edge can be selected. A one-cycle strobe then moves the shifted bits to the register outputs.

A refresh starts in one of two ways. Software can request one, or a periodic timer can start one at one of four programmable rates. In the output word, any of the eight lowest bits can be taken from hardware status inputs instead of the software data word: two modem status lines and two 3-bit PHY status groups. This lets link LEDs follow hardware state without software involvement.

The shift sequencer is a four-state machine:
- `IDLE` moves to `LEAD` when a start is pending and the length is non-zero, and straight to `STROBE` when the length is zero.
- `LEAD` (first half of a bit, shift clock at its idle level) moves to `TRAIL` after `HALF_CLKS` cycles.
- `TRAIL` (second half of a bit, shift clock at the opposite level) moves back to `LEAD` for the next bit, or to `STROBE` after bit 0.
- `STROBE` (latch pulse) always returns to `IDLE`.

Top module: `led_shift_ctrl`

## Requirements
- R1: During and after reset, control 0 reads 0x8000_0000 and control 1, data 0, data 1 and the spare register read zero; `ser_latch` is low while reset is held.
- R2: Registers sit at byte offsets 0x00 (control 0), 0x04 (control 1), 0x08 (data 0), 0x0C (data 1) and 0x10 (spare). Data 0, data 1 and the spare register read back the full written word. Control 0 keeps bits 29:27, 26 and 25:24. Control 1 keeps bits 31:30, 24:23, 17:15 and 2:0. All other bits, and all unmapped offsets, read zero.
- R3: The group-enable field (control 1 bits 2:0) sets the shift length to 8, 16 or 24 bits, according to its highest set bit (bit 0, 1 or 2). A field of zero gives a length of 0.
- R4: Bits go out from bit length-1 down to bit 0. Each bit is held on `ser_data` for one whole shift-clock period, and one sampling edge falls in the middle of each bit.
- R5: Control 0 bit 26 = 1 makes the falling edge of `ser_clk` the sampling edge, with the clock idling high. Bit 26 = 0 makes the rising edge the sampling edge, with the clock idling low.
- R6: After the last bit, `ser_latch` is high for exactly one cycle. A length of 0 produces the strobe alone, with no sampling edges.
- R7: Writing 1 to control 0 bit 31 starts a refresh. Bit 31 reads 1 until that refresh has strobed and then reads 0. Writing 0 to bit 31 starts nothing.
- R8: A request written while a refresh is running is held. It starts a second complete refresh after the current one ends.
- R9: Control 0 bits 25:24 hand output bits 1:0 to `dsl_stat[1:0]`. A set bit selects the status input, a clear bit selects data 0. The inputs are sampled when a refresh starts.
- R10: Control 0 bits 29:27 hand output bits 4:2 to `phy1_stat[2:0]`. Control 1 bits 17:15 hand output bits 7:5 to `phy2_stat[2:0]`. Status lines whose select bit is clear have no effect.
- R11: Periodic refresh runs only while control 1 bit 31 is set. With bit 31 clear (source field 00 or 01), no refresh starts on its own.
- R12: Control 1 bits 24:23 pick the refresh period: 0 selects `DIV_R0` cycles, 1 selects `DIV_R1`, 2 selects `DIV_R2` and 3 selects `DIV_R3`. Consecutive periodic strobes are exactly that many cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the refresh timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| dsl_stat | input | 2 | Modem status lines for output bits 1:0 |
| phy1_stat | input | 3 | First PHY status group for output bits 4:2 |
| phy2_stat | input | 3 | Second PHY status group for output bits 7:5 |
| ser_data | output | 1 | Serial data to the cascade |
| ser_clk | output | 1 | Shift clock to the cascade |
| ser_latch | output | 1 | Storage strobe, one cycle per refresh |

## Verification
If the bit index, the captured word or the sequencer state is wrong, the bit stream that an external register chain collects is wrong. Either the collected word differs or the number of sampling edges between strobes differs, and this shows at the strobe that ends the same refresh. A request flag that clears at the wrong point shows in control 0 bit 31 in the cycle after the strobe. A lost queued request shows as a missing second strobe. A timer that counts wrongly shows as a strobe spacing other than the programmed period, seen in the first full period after the rate is set.

// File: rtl/stp_pkg.sv
package stp_pkg;

    // Cascade geometry and the number of bits that status inputs may own
    localparam int unsigned GRP_CNT  = 3;
    localparam int unsigned GRP_BITS = 8;
    localparam int unsigned HW_BITS  = 8;
    localparam int unsigned ADDR_W   = 5;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFF_CTL0  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CTL1  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_DATA0 = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_DATA1 = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_SPARE = 5'h10;

    // Configuration held in the two control registers
    typedef struct packed {
        logic [2:0] phy1_own;   // ctl0[29:27]
        logic       edge_fall;  // ctl0[26]
        logic [1:0] dsl_own;    // ctl0[25:24]
        logic [1:0] src;        // ctl1[31:30]
        logic [1:0] rate;       // ctl1[24:23]
        logic [2:0] phy2_own;   // ctl1[17:15]
        logic [2:0] grp_en;     // ctl1[2:0]
    } stp_cfg_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LEAD,
        SH_TRAIL,
        SH_STROBE
    } sh_state_t;

endpackage

// File: rtl/stp_regs.sv
module stp_regs
    import stp_pkg::*;
#(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output stp_cfg_t          cfg_o,
    output logic [WORD_W-1:0] data_o,
    output logic              req_pend_o,
    input  logic              req_take_i,
    input  logic              shift_done_i
);

    stp_cfg_t    cfg_q;
    logic [31:0] data0_q;
    logic [31:0] data1_q;
    logic [31:0] spare_q;
    logic        req_q;      // request waiting for the sequencer
    logic        sw_busy_q;  // a software-started refresh is running
    logic        wr_en;
    logic        req_rd;

    assign wr_en  = bus_valid && bus_write;
    assign req_rd = req_q | sw_busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            data0_q   <= '0;
            data1_q   <= '0;
            spare_q   <= '0;
            req_q     <= 1'b1;
            sw_busy_q <= 1'b0;
        end else begin
            if (req_take_i) begin
                req_q     <= 1'b0;
                sw_busy_q <= 1'b1;
            end
            if (shift_done_i) begin
                sw_busy_q <= 1'b0;
            end
            if (wr_en) begin
                case (bus_addr)
                    OFF_CTL0: begin
                        cfg_q.phy1_own  <= bus_wdata[29:27];
                        cfg_q.edge_fall <= bus_wdata[26];
                        cfg_q.dsl_own   <= bus_wdata[25:24];
                        if (bus_wdata[31]) begin
                            req_q <= 1'b1;
                        end
                    end
                    OFF_CTL1: begin
                        cfg_q.src      <= bus_wdata[31:30];
                        cfg_q.rate     <= bus_wdata[24:23];
                        cfg_q.phy2_own <= bus_wdata[17:15];
                        cfg_q.grp_en   <= bus_wdata[2:0];
                    end
                    OFF_DATA0: data0_q <= bus_wdata;
                    OFF_DATA1: data1_q <= bus_wdata;
                    OFF_SPARE: spare_q <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_CTL0:  bus_rdata = {req_rd, 1'b0, cfg_q.phy1_own, cfg_q.edge_fall,
                                    cfg_q.dsl_own, 24'b0};
            OFF_CTL1:  bus_rdata = {cfg_q.src, 5'b0, cfg_q.rate, 5'b0,
                                    cfg_q.phy2_own, 12'b0, cfg_q.grp_en};
            OFF_DATA0: bus_rdata = data0_q;
            OFF_DATA1: bus_rdata = data1_q;
            OFF_SPARE: bus_rdata = spare_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign cfg_o      = cfg_q;
    assign data_o     = data0_q[WORD_W-1:0];
    assign req_pend_o = req_q;

    // R7: the visible request flag drops only on the cycle after a strobe
    a_r7_req_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_rd) |-> $past(shift_done_i));

endmodule

// File: rtl/stp_rate_timer.sv
module stp_rate_timer #(
    parameter int unsigned DIV_R0 = 125_000_000,
    parameter int unsigned DIV_R1 = 62_500_000,
    parameter int unsigned DIV_R2 = 31_250_000,
    parameter int unsigned DIV_R3 = 25_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] rate_i,
    output logic       tick_o
);

    localparam int unsigned DIVS [4] = '{DIV_R0, DIV_R1, DIV_R2, DIV_R3};
    localparam int unsigned MAX01 = (DIV_R0 > DIV_R1) ? DIV_R0 : DIV_R1;
    localparam int unsigned MAX23 = (DIV_R2 > DIV_R3) ? DIV_R2 : DIV_R3;
    localparam int unsigned MAXD  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int unsigned CNT_W = (MAXD > 2) ? $clog2(MAXD) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    assign lim = CNT_W'(DIVS[rate_i] - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= lim) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R11: a disabled source never produces a refresh tick
    a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick_o);

    // R12: every tick is a single-cycle pulse
    a_r12_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/stp_merge.sv
module stp_merge
    import stp_pkg::*;
#(
    parameter int unsigned WORD_W = GRP_CNT * GRP_BITS,
    parameter int unsigned LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0]  data_i,
    input  logic [1:0]         dsl_own_i,
    input  logic [2:0]         phy1_own_i,
    input  logic [2:0]         phy2_own_i,
    input  logic [1:0]         dsl_i,
    input  logic [2:0]         phy1_i,
    input  logic [2:0]         phy2_i,
    input  logic [GRP_CNT-1:0] grp_en_i,
    output logic [WORD_W-1:0]  word_o,
    output logic [LEN_W-1:0]   len_o
);

    logic [HW_BITS-1:0] own;
    logic [HW_BITS-1:0] hw;

    assign own = {phy2_own_i, phy1_own_i, dsl_own_i};
    assign hw  = {phy2_i, phy1_i, dsl_i};

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (b < HW_BITS) begin : g_hw
            assign word_o[b] = own[b] ? hw[b] : data_i[b];
        end else begin : g_cpu
            assign word_o[b] = data_i[b];
        end
    end

    // Length follows the highest enabled group
    always_comb begin
        len_o = '0;
        for (int g = 0; g < GRP_CNT; g++) begin
            if (grp_en_i[g]) begin
                len_o = LEN_W'((g + 1) * GRP_BITS);
            end
        end
    end

endmodule

// File: rtl/stp_shifter.sv
module stp_shifter
    import stp_pkg::*;
#(
    parameter int unsigned WORD_W    = 24,
    parameter int unsigned LEN_W     = $clog2(WORD_W + 1),
    parameter int unsigned HALF_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              edge_fall_i,
    output logic              launch_o,
    output logic              done_o,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              ser_latch_o
);

    localparam int unsigned HC_W = (HALF_CLKS > 2) ? $clog2(HALF_CLKS) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CLKS - 1);

    sh_state_t         state_q;
    sh_state_t         state_nx;
    logic [WORD_W-1:0] word_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic [HC_W-1:0]   hcnt_q;

    assign launch_o = (state_q == SH_IDLE) && start_i;

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SH_IDLE: begin
                if (start_i) begin
                    state_nx = (len_i == '0) ? SH_STROBE : SH_LEAD;
                end
            end
            SH_LEAD: begin
                if (hcnt_q == HC_LAST) begin
                    state_nx = SH_TRAIL;
                end
            end
            SH_TRAIL: begin
                if (hcnt_q == HC_LAST) begin
                    state_nx = (idx_q == '0) ? SH_STROBE : SH_LEAD;
                end
            end
            SH_STROBE: state_nx = SH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Word, bit index and half-period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
            len_q  <= '0;
            hcnt_q <= '0;
        end else begin
            if (state_q != state_nx) begin
                hcnt_q <= '0;
            end else if (state_q == SH_LEAD || state_q == SH_TRAIL) begin
                hcnt_q <= hcnt_q + 1'b1;
            end
            if (launch_o) begin
                word_q <= word_i;
                len_q  <= len_i;
                idx_q  <= len_i - 1'b1;
            end else if (state_q == SH_TRAIL && state_nx == SH_LEAD) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ser_data_o  = 1'b0;
        ser_clk_o   = edge_fall_i;
        ser_latch_o = 1'b0;
        unique case (state_q)
            SH_IDLE:   ;
            SH_LEAD:   ser_data_o = word_q[idx_q];
            SH_TRAIL: begin
                ser_data_o = word_q[idx_q];
                ser_clk_o  = ~edge_fall_i;
            end
            SH_STROBE: ser_latch_o = 1'b1;
        endcase
    end

    assign done_o = ser_latch_o;

    // R4: data does not move during the second half of a bit
    a_r4_bit_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_TRAIL) |-> (ser_data_o == $past(ser_data_o)));

    // R6: the storage strobe lasts a single cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        ser_latch_o |=> !ser_latch_o);

    // R3: the bit being shifted always lies inside the captured length
    a_r3_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_LEAD || state_q == SH_TRAIL) |-> (idx_q < len_q));

endmodule

// File: rtl/led_shift_ctrl.sv
module led_shift_ctrl
    import stp_pkg::*;
#(
    parameter int unsigned HALF_CLKS = 4,
    parameter int unsigned DIV_R0    = 125_000_000,
    parameter int unsigned DIV_R1    = 62_500_000,
    parameter int unsigned DIV_R2    = 31_250_000,
    parameter int unsigned DIV_R3    = 25_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  dsl_stat,
    input  logic [2:0]  phy1_stat,
    input  logic [2:0]  phy2_stat,
    output logic        ser_data,
    output logic        ser_clk,
    output logic        ser_latch
);

    localparam int unsigned WORD_W = GRP_CNT * GRP_BITS;
    localparam int unsigned LEN_W  = $clog2(WORD_W + 1);

    stp_cfg_t          cfg;
    logic [WORD_W-1:0] data_word;
    logic [WORD_W-1:0] merged;
    logic [LEN_W-1:0]  len;
    logic              req_pend;
    logic              req_take;
    logic              launch;
    logic              done;
    logic              tick;
    logic              timer_en;

    assign timer_en = (cfg.src >= 2'b10);
    assign req_take = launch && req_pend;

    stp_regs #(.WORD_W(WORD_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .cfg_o        (cfg),
        .data_o       (data_word),
        .req_pend_o   (req_pend),
        .req_take_i   (req_take),
        .shift_done_i (done)
    );

    stp_rate_timer #(
        .DIV_R0 (DIV_R0),
        .DIV_R1 (DIV_R1),
        .DIV_R2 (DIV_R2),
        .DIV_R3 (DIV_R3)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (timer_en),
        .rate_i (cfg.rate),
        .tick_o (tick)
    );

    stp_merge #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_merge (
        .data_i     (data_word),
        .dsl_own_i  (cfg.dsl_own),
        .phy1_own_i (cfg.phy1_own),
        .phy2_own_i (cfg.phy2_own),
        .dsl_i      (dsl_stat),
        .phy1_i     (phy1_stat),
        .phy2_i     (phy2_stat),
        .grp_en_i   (cfg.grp_en),
        .word_o     (merged),
        .len_o      (len)
    );

    stp_shifter #(
        .WORD_W    (WORD_W),
        .LEN_W     (LEN_W),
        .HALF_CLKS (HALF_CLKS)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (req_pend | tick),
        .word_i      (merged),
        .len_i       (len),
        .edge_fall_i (cfg.edge_fall),
        .launch_o    (launch),
        .done_o      (done),
        .ser_data_o  (ser_data),
        .ser_clk_o   (ser_clk),
        .ser_latch_o (ser_latch)
    );

endmodule

// File: tb/tb_led_shift_ctrl.sv
`timescale 1ns/1ps
module tb_led_shift_ctrl;

    localparam int unsigned HALF = 2;
    localparam int unsigned D0 = 400;
    localparam int unsigned D1 = 300;
    localparam int unsigned D2 = 200;
    localparam int unsigned D3 = 150;
    localparam int unsigned DIVS [4] = '{D0, D1, D2, D3};

    typedef struct packed {
        logic [2:0]  grp;
        logic        fall;
        logic [1:0]  dsl_own;
        logic [2:0]  p1_own;
        logic [2:0]  p2_own;
        logic [1:0]  dsl_in;
        logic [2:0]  p1_in;
        logic [2:0]  p2_in;
        logic [23:0] data;
        logic [23:0] exp_word;
        logic [4:0]  exp_len;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'b001, 1'b0, 2'b00, 3'b000, 3'b000, 2'b00, 3'b000, 3'b000, 24'h0000A5, 24'h0000A5, 5'd8},
        '{3'b011, 1'b1, 2'b00, 3'b000, 3'b000, 2'b00, 3'b000, 3'b000, 24'h00C33C, 24'h00C33C, 5'd16},
        '{3'b111, 1'b0, 2'b00, 3'b000, 3'b000, 2'b00, 3'b000, 3'b000, 24'h81F00F, 24'h81F00F, 5'd24},
        '{3'b100, 1'b1, 2'b00, 3'b000, 3'b000, 2'b00, 3'b000, 3'b000, 24'h123456, 24'h123456, 5'd24},
        '{3'b001, 1'b1, 2'b11, 3'b000, 3'b000, 2'b10, 3'b000, 3'b000, 24'h0000FF, 24'h0000FE, 5'd8},
        '{3'b001, 1'b0, 2'b00, 3'b101, 3'b000, 2'b00, 3'b011, 3'b000, 24'h000000, 24'h000004, 5'd8},
        '{3'b011, 1'b1, 2'b01, 3'b000, 3'b111, 2'b00, 3'b000, 3'b110, 24'h00ABFF, 24'h00ABDE, 5'd16},
        '{3'b000, 1'b0, 2'b00, 3'b000, 3'b000, 2'b00, 3'b000, 3'b000, 24'h000055, 24'h000000, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  dsl_stat = '0;
    logic [2:0]  phy1_stat = '0;
    logic [2:0]  phy2_stat = '0;
    logic        ser_data;
    logic        ser_clk;
    logic        ser_latch;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    led_shift_ctrl #(
        .HALF_CLKS (HALF),
        .DIV_R0    (D0),
        .DIV_R1    (D1),
        .DIV_R2    (D2),
        .DIV_R3    (D3)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dsl_stat  (dsl_stat),
        .phy1_stat (phy1_stat),
        .phy2_stat (phy2_stat),
        .ser_data  (ser_data),
        .ser_clk   (ser_clk),
        .ser_latch (ser_latch)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    // Called just after a falling clock edge; read data is combinational
    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Acts as the external register chain: shifts on the sampling edge until the strobe
    task automatic collect(input logic fall, output logic [23:0] word,
                           output int nbits, output int ncyc);
        logic prev;
        bit   seen;
        word  = '0;
        nbits = 0;
        ncyc  = 0;
        seen  = 0;
        prev  = ser_clk;
        while (!seen && ncyc < 5000) begin
            @(negedge clk);
            ncyc++;
            if (ser_clk !== prev && ser_clk === ~fall) begin
                word = {word[22:0], ser_data};
                nbits++;
            end
            prev = ser_clk;
            if (ser_latch) seen = 1;
        end
        if (!seen) begin
            checks++;
            errors++;
            $display("FAIL R6: strobe missing, actual 0 expected 1");
        end
    endtask

    task automatic count_latches(input int ncyc, output int cnt);
        cnt = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (ser_latch) cnt++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [23:0] w;
        int nb;
        int nc;
        int cnt;

        // R1: state while reset is held
        repeat (3) @(negedge clk);
        bus_rd(5'h00, rd); check("R1 ctl0 reset", rd, 32'h8000_0000);
        bus_rd(5'h04, rd); check("R1 ctl1 reset", rd, 32'h0);
        bus_rd(5'h08, rd); check("R1 data0 reset", rd, 32'h0);
        bus_rd(5'h0C, rd); check("R1 data1 reset", rd, 32'h0);
        bus_rd(5'h10, rd); check("R1 spare reset", rd, 32'h0);
        check("R1 latch low in reset", {31'b0, ser_latch}, 32'h0);

        // R6/R7: the pending request at reset is served with zero length
        rst_n = 1'b1;
        collect(1'b0, w, nb, nc);
        check("R6 zero length bit count", nb, 0);
        @(negedge clk);
        bus_rd(5'h00, rd); check("R7 request cleared after strobe", rd, 32'h0);

        // R2: register readback and unused bits
        bus_wr(5'h08, 32'hDEAD_BEEF); bus_rd(5'h08, rd); check("R2 data0", rd, 32'hDEAD_BEEF);
        bus_wr(5'h0C, 32'h1234_5678); bus_rd(5'h0C, rd); check("R2 data1", rd, 32'h1234_5678);
        bus_wr(5'h10, 32'hCAFE_F00D); bus_rd(5'h10, rd); check("R2 spare", rd, 32'hCAFE_F00D);
        bus_wr(5'h00, 32'h7FFF_FFFF); bus_rd(5'h00, rd); check("R2 ctl0 fields", rd, 32'h3F00_0000);
        bus_wr(5'h04, 32'hFFFF_FFFF); bus_rd(5'h04, rd); check("R2 ctl1 fields", rd, 32'hC183_8007);
        bus_wr(5'h04, 32'h0);
        bus_rd(5'h14, rd); check("R2 unmapped offset", rd, 32'h0);
        repeat (120) @(negedge clk);

        // Vector table: R3 R4 R5 R7 R9 R10
        for (int v = 0; v < NV; v++) begin
            dsl_stat  = VECS[v].dsl_in;
            phy1_stat = VECS[v].p1_in;
            phy2_stat = VECS[v].p2_in;
            bus_wr(5'h04, {17'b0, VECS[v].p2_own, 12'b0, VECS[v].grp});
            bus_wr(5'h08, {8'b0, VECS[v].data});
            bus_wr(5'h00, {1'b0, 1'b0, VECS[v].p1_own, VECS[v].fall, VECS[v].dsl_own, 24'b0});
            bus_wr(5'h00, {1'b1, 1'b0, VECS[v].p1_own, VECS[v].fall, VECS[v].dsl_own, 24'b0});
            bus_rd(5'h00, rd);
            check("R7 request visible", {31'b0, rd[31]}, 32'h1);
            collect(VECS[v].fall, w, nb, nc);
            check("R3 bit count", nb, {27'b0, VECS[v].exp_len});
            check("R4 R5 R9 R10 shifted word", {8'b0, w}, {8'b0, VECS[v].exp_word});
            @(negedge clk);
            bus_rd(5'h00, rd);
            check("R7 request cleared", {31'b0, rd[31]}, 32'h0);
        end

        // R8: request queued during a running refresh
        bus_wr(5'h04, 32'h0000_0001);
        bus_wr(5'h08, 32'h0000_003C);
        bus_wr(5'h00, 32'h8000_0000);
        repeat (6) @(negedge clk);
        bus_wr(5'h00, 32'h8000_0000);
        collect(1'b0, w, nb, nc);
        @(negedge clk);
        bus_rd(5'h00, rd);
        check("R8 queued request still visible", {31'b0, rd[31]}, 32'h1);
        collect(1'b0, w, nb, nc);
        check("R8 queued refresh bits", nb, 8);
        check("R8 queued refresh word", {8'b0, w}, 32'h3C);
        @(negedge clk);
        bus_rd(5'h00, rd);
        check("R8 request cleared after second", {31'b0, rd[31]}, 32'h0);

        // R7: writing zero to the request bit starts nothing
        bus_wr(5'h00, 32'h0000_0000);
        count_latches(300, cnt);
        check("R7 zero write no refresh", cnt, 0);

        // R11/R12/R9: periodic refresh at each rate with the modem lines owning bits 1:0
        bus_wr(5'h08, 32'h0000_0080);
        bus_wr(5'h00, 32'h0300_0000);
        for (int r = 0; r < 4; r++) begin
            dsl_stat = 2'(r);
            bus_wr(5'h04, 32'h8000_0001 | (32'(r) << 23));
            collect(1'b0, w, nb, nc);
            collect(1'b0, w, nb, nc);
            check("R12 strobe spacing", nc, DIVS[r]);
            check("R9 periodic word", {8'b0, w}, 32'h80 | 32'(r));
        end

        // R11: source 01 and 00 are both off
        bus_wr(5'h04, 32'h4000_0001);
        repeat (60) @(negedge clk);
        count_latches(1000, cnt);
        check("R11 source 01 off", cnt, 0);
        bus_wr(5'h04, 32'h0000_0001);
        count_latches(500, cnt);
        check("R11 source 00 off", cnt, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule